// File: doc/BRIEF.md
# Reference Clock Ratio Detector

This block decides which oscillator-to-reference divide ratio a frequency synthesis loop should use, without any configuration pin. The oscillator runs at roughly 2.5 to 2.7 GHz and the loop supports exactly three ratios: 16, 32 and 128. Each ratio therefore maps to its own band of reference frequencies. The block measures the reference and reports which band it falls in.

A free-running local clock times a measurement window of `WIN_CYCLES` cycles. A counter in the reference domain counts edges in Gray code. That count crosses into the local domain through two flops. At the end of each window the block takes the number of edges seen and sorts it into a band. The ratio code only moves after two windows in a row agree, so one corrupted window cannot change it. Measurement never stops, so the code follows a change of reference by itself.

Band limits come from the parameters: an oscillator range of 2.4 to 2.8 GHz (the nominal range plus margin), the local clock rate and the window length. With the defaults (100 MHz local clock, 1000-cycle window) the bands are the ones listed below.

Top module: `refclk_ratio_detect`

## Requirements
- R1: While reset is held and right after it is released, `ratio_code` is 2'b00 and `ref_present` is low.
- R2: A reference between 18.75 and 21.875 MHz (for example 19.44, 19.53 or 20.83 MHz) drives `ratio_code` to 2'b11, meaning divide by 128.
- R3: A reference between 75 and 87.5 MHz (for example 77.76, 78.125 or 83.31 MHz) drives `ratio_code` to 2'b10, meaning divide by 32.
- R4: A reference between 150 and 175 MHz (for example 155.52 or 156.25 MHz) drives `ratio_code` to 2'b01, meaning divide by 16.
- R5: A reference outside all three bands, including one that has stopped, drives `ratio_code` to 2'b00 and `ref_present` low.
- R6: `ref_present` is high exactly when `ratio_code` is non-zero.
- R7: `ratio_code` changes only when two consecutive windows classify into the same new band. A single window that lands in a different band leaves the code unchanged.
- R8: `ratio_code` changes only on the clock edge that closes a window. Windows close every `WIN_CYCLES` local cycles, counted from reset release.
- R9: Measurement is continuous. After the reference changes to a steady new frequency, the code shows the new band within three windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running local clock that times the measurement window |
| rst_n | input | 1 | Active-low asynchronous reset for both clock domains |
| ref_clk | input | 1 | Reference clock being measured |
| ratio_code | output | 2 | Selected ratio: 00 none, 01 = 16, 10 = 32, 11 = 128 |
| ref_present | output | 1 | High when the reference falls in a supported band |

## Verification
The assertions assume the reference is either stopped or runs at a steady rate well below the point where the edge counter would wrap within one window. They also assume the local clock never stops, so each window has a fixed length.

Stimulus keeps to these limits:
- Random frequencies are drawn from the nominal oscillator range divided by a ratio, or from gaps that sit well clear of every band edge.
- Every frequency is held for at least three windows.
- The single-window disturbance is aligned to the window grid, which the bench tracks from reset release.

// File: rtl/refclk_ratio_detect.sv
module refclk_ratio_detect #(
  parameter int LCL_KHZ    = 100000,
  parameter int WIN_CYCLES = 1000,
  parameter int VCO_LO_MHZ = 2400,
  parameter int VCO_HI_MHZ = 2800
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_clk,
  output logic [1:0] ratio_code,
  output logic       ref_present
);

  localparam longint NUM_LO = longint'(VCO_LO_MHZ) * 1000 * WIN_CYCLES;
  localparam longint NUM_HI = longint'(VCO_HI_MHZ) * 1000 * WIN_CYCLES;
  localparam int LO16  = int'(NUM_LO / (longint'(LCL_KHZ) * 16));
  localparam int HI16  = int'(NUM_HI / (longint'(LCL_KHZ) * 16));
  localparam int LO32  = int'(NUM_LO / (longint'(LCL_KHZ) * 32));
  localparam int HI32  = int'(NUM_HI / (longint'(LCL_KHZ) * 32));
  localparam int LO128 = int'(NUM_LO / (longint'(LCL_KHZ) * 128));
  localparam int HI128 = int'(NUM_HI / (longint'(LCL_KHZ) * 128));
  localparam int CW    = $clog2(HI16 * 2) + 1;
  localparam int WW    = $clog2(WIN_CYCLES);

  localparam logic [CW-1:0] L16  = CW'(LO16);
  localparam logic [CW-1:0] H16  = CW'(HI16);
  localparam logic [CW-1:0] L32  = CW'(LO32);
  localparam logic [CW-1:0] H32  = CW'(HI32);
  localparam logic [CW-1:0] L128 = CW'(LO128);
  localparam logic [CW-1:0] H128 = CW'(HI128);

  function automatic logic [1:0] classify(input logic [CW-1:0] n);
    if (n >= L16 && n <= H16)   return 2'b01;
    if (n >= L32 && n <= H32)   return 2'b10;
    if (n >= L128 && n <= H128) return 2'b11;
    return 2'b00;
  endfunction

  logic [CW-1:0] rbin, rgray, rnext;
  assign rnext = rbin + 1'b1;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else begin
      rbin  <= rnext;
      rgray <= rnext ^ (rnext >> 1);
    end
  end

  logic [CW-1:0] sync1, sync2, sbin, last_bin, delta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= rgray;
      sync2 <= sync1;
    end
  end

  always_comb begin
    for (int i = 0; i < CW; i++) sbin[i] = ^(sync2 >> i);
  end

  assign delta = sbin - last_bin;

  logic [WW-1:0] wcnt;
  logic          tick;
  logic [1:0]    band_now, pend_band;

  assign tick     = (wcnt == WW'(WIN_CYCLES - 1));
  assign band_now = classify(delta);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt       <= '0;
      last_bin   <= '0;
      pend_band  <= 2'b00;
      ratio_code <= 2'b00;
    end else begin
      wcnt <= tick ? '0 : wcnt + 1'b1;
      if (tick) begin
        last_bin  <= sbin;
        pend_band <= band_now;
        if (band_now == pend_band) ratio_code <= band_now;
      end
    end
  end

  assign ref_present = |ratio_code;

  a_r8_hold_between_windows: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(ratio_code));

  a_r7_two_window_agree: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_code != $past(ratio_code)) |-> (ratio_code == $past(pend_band)));

  a_r2_enter128: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_code == 2'b11 && $past(ratio_code) != 2'b11) |->
      ($past(delta) >= L128 && $past(delta) <= H128));

  a_r3_enter32: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_code == 2'b10 && $past(ratio_code) != 2'b10) |->
      ($past(delta) >= L32 && $past(delta) <= H32));

  a_r4_enter16: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_code == 2'b01 && $past(ratio_code) != 2'b01) |->
      ($past(delta) >= L16 && $past(delta) <= H16));

  a_r5_enter_none: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_code == 2'b00 && $past(ratio_code) != 2'b00) |->
      !(($past(delta) >= L16 && $past(delta) <= H16) ||
        ($past(delta) >= L32 && $past(delta) <= H32) ||
        ($past(delta) >= L128 && $past(delta) <= H128)));

endmodule

// File: tb/refclk_ratio_detect_tb_top.sv
`timescale 1ns/1ps
module refclk_ratio_detect_tb_top;
  localparam int WIN = 1000;

  logic clk = 1'b0, rst_n = 1'b0, ref_clk = 1'b0;
  logic [1:0] ratio_code;
  logic ref_present;
  real ref_half = 0.0;
  int  cyc = 0;
  int  n_chk = 0, n_bad = 0;
  bit  done = 1'b0;
  logic [1:0] prev_code = 2'b00;

  refclk_ratio_detect #(.WIN_CYCLES(WIN)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk),
    .ratio_code(ratio_code), .ref_present(ref_present));

  always #5 clk = ~clk;

  initial begin
    forever begin
      if (ref_half == 0.0) begin
        ref_clk = 1'b0;
        #1;
      end else begin
        #(ref_half) ref_clk = ~ref_clk;
      end
    end
  end

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  function automatic logic [1:0] expect_code(real f);
    if (f >= 18.75 && f <= 21.875) return 2'b11;
    if (f >= 75.0  && f <= 87.5)   return 2'b10;
    if (f >= 150.0 && f <= 175.0)  return 2'b01;
    return 2'b00;
  endfunction

  task automatic chk(string req, logic [1:0] got, logic [1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic set_freq(real f);
    ref_half = (f == 0.0) ? 0.0 : 500.0 / f;
  endtask

  task automatic settle_and_check(string req, real f);
    set_freq(f);
    repeat (3 * WIN + 20) @(posedge clk);
    @(negedge clk);
    chk(req, ratio_code, expect_code(f));
    chk("R6", {1'b0, ref_present}, {1'b0, expect_code(f) != 2'b00});
  endtask

  always @(negedge clk) begin
    if (rst_n && !done && ratio_code !== prev_code) begin
      n_chk++;
      if (cyc % WIN != 0) begin
        n_bad++;
        $display("FAIL R8: code changed at cycle %0d, expected multiple of %0d", cyc, WIN);
      end
    end
    prev_code <= ratio_code;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R1", ratio_code, 2'b00);
    chk("R1", {1'b0, ref_present}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", ratio_code, 2'b00);

    settle_and_check("R2", 19.44);
    settle_and_check("R3", 77.76);
    settle_and_check("R4", 155.52);
    settle_and_check("R2", 20.83);
    settle_and_check("R4", 156.25);
    settle_and_check("R5", 0.0);
    settle_and_check("R3", 83.31);
    settle_and_check("R5", 50.0);
    settle_and_check("R3", 78.125);
    settle_and_check("R5", 120.0);
    settle_and_check("R2", 19.53);

    // R7: one window at 156.25 MHz aligned to the window grid must not move the code
    begin
      bit moved = 1'b0;
      while (cyc % WIN != 30) @(negedge clk);
      set_freq(156.25);
      while (cyc % WIN != WIN - 30) begin
        @(negedge clk);
        if (ratio_code !== 2'b11) moved = 1'b1;
      end
      set_freq(19.44);
      repeat (2 * WIN + 10) begin
        @(negedge clk);
        if (ratio_code !== 2'b11) moved = 1'b1;
      end
      chk("R7", {1'b0, moved}, 2'b00);
    end

    // R9: random references, held steady long enough for re-evaluation
    for (int k = 0; k < 16; k++) begin
      real f;
      int kind = int'($urandom % 4);
      int vco  = 2500 + int'($urandom % 201);
      case (kind)
        0: f = real'(vco) / 16.0;
        1: f = real'(vco) / 32.0;
        2: f = real'(vco) / 128.0;
        default: begin
          int gap = int'($urandom % 3);
          if (gap == 0)      f = 30.0 + real'($urandom % 40);
          else if (gap == 1) f = 100.0 + real'($urandom % 31);
          else               f = 190.0 + real'($urandom % 51);
        end
      endcase
      settle_and_check("R9", f);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule